// File: doc/BRIEF.md
# Multiplexed-D Scan Chain Wrapper

This block holds a design's state flip-flops as scan cells. Each cell is a D flip-flop with a 2:1 selector on its data input. One test-control input sets the mode for every cell at once:

- When test control is high, each cell captures its bit of the functional next-state bus.
- When test control is low, the cells form shift chains. Each cell takes the value of its neighbour closer to the chain head.

The cells are split across a parameterised number of chains, and each chain has its own length. Every chain takes its serial input from one shared input pin and drives its serial output onto one shared output pin. In normal mode those same pins carry a functional input into the core and a functional output from the core. Test control is therefore the only pin the block adds.

A single clock from a primary input drives every cell, and no clock reaches any data path. A synchronous reset sets every cell to zero. A test program uses the block in three steps:

1. Shift a pattern in, with test control low, for as many cycles as the longest chain holds.
2. Capture one functional response, with test control high.
3. Shift the response out on the shared output pins while the next pattern goes in.

Top module: `scan_chain_wrap`

## Requirements
- R1: When `syncRst` is 1 at a rising clock edge, every bit of `presentState` is 0 after that edge, whatever the values of `testCtl`, `nextState` and `pinIn`.
- R2: With `testCtl` = 1 (normal mode) and no reset, `presentState` after an edge equals `nextState` before that edge.
- R3: With `testCtl` = 0 (scan mode) and no reset, the following hold after an edge, and `nextState` has no effect:
  - the head cell of chain c holds the previous `pinIn[c]`;
  - every other cell holds the previous value of its lower-numbered neighbour in the same chain.
- R4: With `testCtl` = 1, `pinOut` equals `coreOut` bit for bit.
- R5: With `testCtl` = 0, `pinOut[c]` equals the tail cell of chain c.
- R6: With `testCtl` = 1, `coreIn` equals `pinIn`. With `testCtl` = 0, `coreIn` is all zeros.
- R7: The cell layout in `presentState` is as follows:
  - Chain c occupies `LEN[c]` consecutive bits, starting at the sum of the lengths of chains 0 to c-1.
  - `LEN[c]` is byte c of `LEN_PACK`.
  - The lowest of a chain's bits is its head, next to `pinIn[c]`, and the highest is its tail.
  - After N shift cycles, with N at least `LEN[c]`, the cell at position k of chain c holds the bit applied on cycle N-1-k.
- R8: After one capture, shifting makes each chain's `pinOut` present the captured bits tail first. Each cycle brings the next lower cell's bit forward, then the bits shifted in.
- R9: A chain of length 1 works alone:
  - its single cell is both head and tail;
  - its `pinOut` in scan mode tracks the `pinIn` of the previous shift cycle;
  - shifting it the longest chain's number of cycles leaves only the last applied bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for every cell, taken straight from a pin |
| syncRst | input | 1 | Synchronous reset, active high, clears all cells |
| testCtl | input | 1 | 1 selects normal capture, 0 selects scan shift |
| nextState | input | STATE_W | Functional next-state bits from the combinational logic |
| presentState | output | STATE_W | Present-state bits from the cells to the combinational logic |
| pinIn | input | CHAINS | Shared pins: functional inputs, or chain serial inputs in scan mode |
| coreIn | output | CHAINS | Functional inputs passed to the core, zero in scan mode |
| coreOut | input | CHAINS | Functional outputs from the core |
| pinOut | output | CHAINS | Shared pins: functional outputs, or chain serial outputs in scan mode |

## Verification
The bench builds the block with three chains of lengths 5, 3 and 1 (`LEN_PACK` = 24'h010305), nine cells in all. Because the lengths are unequal, a five-cycle load overshoots the two shorter chains. This shows that each chain keeps only its last bits, and that the offsets of the later chains in `presentState` are right. The single-cell chain tests the case where head and tail are the same cell. The bench also interleaves captures, shifts and resets in both modes, so reset priority and the mode changeover on the shared pins are both reached.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef struct packed {
    logic clear;
    logic capture;
    logic shift;
  } cellStrobes_t;

  localparam int FIELD_W = 8;
  localparam int PACK_W  = 256;

  function automatic int packField(input logic [PACK_W-1:0] v, input int idx);
    return int'(v[idx*FIELD_W +: FIELD_W]);
  endfunction

  function automatic int packOffset(input logic [PACK_W-1:0] v, input int idx);
    int acc;
    acc = 0;
    for (int i = 0; i < idx; i++) acc += packField(v, i);
    return acc;
  endfunction

endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
(
  input  logic         syncRst,
  input  logic         testCtl,
  output cellStrobes_t strobes
);
  always_comb begin
    strobes.clear   = syncRst;
    strobes.capture = !syncRst && testCtl;
    strobes.shift   = !syncRst && !testCtl;
  end
endmodule

// File: rtl/scan_cells.sv
module scan_cells
  import scan_pkg::*;
#(
  parameter int CHAINS = 3,
  parameter logic [CHAINS*8-1:0] LEN_PACK = 24'h010305,
  localparam int STATE_W = packOffset(PACK_W'(LEN_PACK), CHAINS)
) (
  input  logic               clk,
  input  cellStrobes_t       strobes,
  input  logic [STATE_W-1:0] nextState,
  input  logic [CHAINS-1:0]  scanIn,
  output logic [STATE_W-1:0] cellQ,
  output logic [CHAINS-1:0]  chainTail
);
  for (genvar c = 0; c < CHAINS; c++) begin : g_chain
    localparam int OFF = packOffset(PACK_W'(LEN_PACK), c);
    localparam int LEN = packField(PACK_W'(LEN_PACK), c);
    for (genvar k = 0; k < LEN; k++) begin : g_cell
      logic shiftSrc;
      logic q;
      if (k == 0) begin : g_head
        assign shiftSrc = scanIn[c];
      end else begin : g_body
        assign shiftSrc = cellQ[OFF+k-1];
      end
      always_ff @(posedge clk) begin
        if (strobes.clear)        q <= 1'b0;
        else if (strobes.capture) q <= nextState[OFF+k];
        else if (strobes.shift)   q <= shiftSrc;
      end
      assign cellQ[OFF+k] = q;
    end
    assign chainTail[c] = cellQ[OFF+LEN-1];
  end
endmodule

// File: rtl/scan_pinmux.sv
module scan_pinmux #(
  parameter int CHAINS = 3
) (
  input  logic              testCtl,
  input  logic [CHAINS-1:0] pinIn,
  input  logic [CHAINS-1:0] coreOut,
  input  logic [CHAINS-1:0] chainTail,
  output logic [CHAINS-1:0] coreIn,
  output logic [CHAINS-1:0] scanIn,
  output logic [CHAINS-1:0] pinOut
);
  always_comb begin
    coreIn = testCtl ? pinIn : '0;
    scanIn = testCtl ? '0 : pinIn;
    pinOut = testCtl ? coreOut : chainTail;
  end
endmodule

// File: rtl/scan_chain_wrap.sv
module scan_chain_wrap
  import scan_pkg::*;
#(
  parameter int CHAINS = 3,
  parameter logic [CHAINS*8-1:0] LEN_PACK = 24'h010305,
  localparam int STATE_W = packOffset(PACK_W'(LEN_PACK), CHAINS)
) (
  input  logic               clk,
  input  logic               syncRst,
  input  logic               testCtl,
  input  logic [STATE_W-1:0] nextState,
  output logic [STATE_W-1:0] presentState,
  input  logic [CHAINS-1:0]  pinIn,
  output logic [CHAINS-1:0]  coreIn,
  input  logic [CHAINS-1:0]  coreOut,
  output logic [CHAINS-1:0]  pinOut
);
  cellStrobes_t       strobes;
  logic [CHAINS-1:0]  scanIn;
  logic [CHAINS-1:0]  chainTail;

  scan_ctrl u_ctrl (
    .syncRst (syncRst),
    .testCtl (testCtl),
    .strobes (strobes)
  );

  scan_cells #(.CHAINS(CHAINS), .LEN_PACK(LEN_PACK)) u_cells (
    .clk       (clk),
    .strobes   (strobes),
    .nextState (nextState),
    .scanIn    (scanIn),
    .cellQ     (presentState),
    .chainTail (chainTail)
  );

  scan_pinmux #(.CHAINS(CHAINS)) u_pins (
    .testCtl   (testCtl),
    .pinIn     (pinIn),
    .coreOut   (coreOut),
    .chainTail (chainTail),
    .coreIn    (coreIn),
    .scanIn    (scanIn),
    .pinOut    (pinOut)
  );
endmodule

// File: rtl/scan_chain_wrap_chk.sv
module scan_chain_wrap_chk
  import scan_pkg::*;
#(
  parameter int CHAINS = 3,
  parameter logic [CHAINS*8-1:0] LEN_PACK = 24'h010305,
  localparam int STATE_W = packOffset(PACK_W'(LEN_PACK), CHAINS)
) (
  input logic               clk,
  input logic               syncRst,
  input logic               testCtl,
  input logic [STATE_W-1:0] nextState,
  input logic [STATE_W-1:0] presentState,
  input logic [CHAINS-1:0]  pinIn,
  input logic [CHAINS-1:0]  coreIn,
  input logic [CHAINS-1:0]  coreOut,
  input logic [CHAINS-1:0]  pinOut
);
  p_reset_clears_r1: assert property (@(posedge clk)
    syncRst |=> presentState == '0);

  p_capture_r2: assert property (@(posedge clk) disable iff (syncRst)
    testCtl |=> presentState == $past(nextState));

  p_func_out_r4: assert property (@(posedge clk) disable iff (syncRst)
    testCtl |-> pinOut == coreOut);

  p_core_in_r6: assert property (@(posedge clk) disable iff (syncRst)
    testCtl |-> coreIn == pinIn);

  p_core_quiet_r6: assert property (@(posedge clk) disable iff (syncRst)
    !testCtl |-> coreIn == '0);

  for (genvar c = 0; c < CHAINS; c++) begin : g_chk
    localparam int OFF = packOffset(PACK_W'(LEN_PACK), c);
    localparam int LEN = packField(PACK_W'(LEN_PACK), c);

    p_scan_out_r5: assert property (@(posedge clk) disable iff (syncRst)
      !testCtl |-> pinOut[c] == presentState[OFF+LEN-1]);

    p_head_shift_r3: assert property (@(posedge clk) disable iff (syncRst)
      !testCtl |=> presentState[OFF] == $past(pinIn[c]));

    for (genvar k = 1; k < LEN; k++) begin : g_body
      p_body_shift_r3: assert property (@(posedge clk) disable iff (syncRst)
        !testCtl |=> presentState[OFF+k] == $past(presentState[OFF+k-1]));
    end
  end
endmodule

bind scan_chain_wrap scan_chain_wrap_chk #(.CHAINS(CHAINS), .LEN_PACK(LEN_PACK)) u_chk (.*);

// File: tb/scan_chain_wrap_bench.sv
module scan_chain_wrap_bench;
  localparam int CHAINS = 3;
  localparam logic [23:0] LENS = 24'h010305;
  localparam int STATE_W = 9;
  localparam int L0 = 5, L1 = 3, L2 = 1;
  localparam int O0 = 0, O1 = 5, O2 = 8;

  logic clk = 1'b0;
  logic syncRst = 1'b1;
  logic testCtl = 1'b1;
  logic [STATE_W-1:0] nextState = '0;
  logic [STATE_W-1:0] presentState;
  logic [CHAINS-1:0] pinIn = '0;
  logic [CHAINS-1:0] coreIn;
  logic [CHAINS-1:0] coreOut = '0;
  logic [CHAINS-1:0] pinOut;

  int total = 0;
  int bad = 0;
  logic [STATE_W-1:0] expState = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  scan_chain_wrap #(.CHAINS(CHAINS), .LEN_PACK(LENS)) u_scan_chain_wrap (
    .clk(clk), .syncRst(syncRst), .testCtl(testCtl),
    .nextState(nextState), .presentState(presentState),
    .pinIn(pinIn), .coreIn(coreIn), .coreOut(coreOut), .pinOut(pinOut)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [STATE_W-1:0] modelStep(input logic [STATE_W-1:0] s, input logic rst,
      input logic tc, input logic [STATE_W-1:0] ns, input logic [CHAINS-1:0] pin);
    logic [STATE_W-1:0] n;
    if (rst) return '0;
    if (tc) return ns;
    n[O0] = pin[0];
    for (int k = 1; k < L0; k++) n[O0+k] = s[O0+k-1];
    n[O1] = pin[1];
    for (int k = 1; k < L1; k++) n[O1+k] = s[O1+k-1];
    n[O2] = pin[2];
    return n;
  endfunction

  task automatic checkPins();
    logic [CHAINS-1:0] tails;
    tails = {expState[O2+L2-1], expState[O1+L1-1], expState[O0+L0-1]};
    if (testCtl) begin
      check(pinOut == coreOut, "R4", pinOut, coreOut);
      check(coreIn == pinIn, "R6", coreIn, pinIn);
    end else begin
      check(pinOut == tails, "R5", pinOut, tails);
      check(coreIn == '0, "R6", coreIn, 0);
    end
  endtask

  // Drive inputs at the falling edge, clock once, check at the next falling edge.
  task automatic cycle(input logic rst, input logic tc, input logic [STATE_W-1:0] ns,
      input logic [CHAINS-1:0] pin, input logic [CHAINS-1:0] co);
    syncRst = rst; testCtl = tc; nextState = ns; pinIn = pin; coreOut = co;
    #1 checkPins();
    @(posedge clk);
    expState = modelStep(expState, rst, tc, ns, pin);
    @(negedge clk);
    check(presentState == expState, rst ? "R1" : (tc ? "R2" : "R3"), presentState, expState);
  endtask

  task automatic t_reset();
    cycle(1'b1, 1'b1, 9'h1FF, 3'b111, 3'b101);
    check(presentState == '0, "R1", presentState, 0);
    cycle(1'b0, 1'b1, 9'h1A5, 3'b010, 3'b011);
    cycle(1'b1, 1'b0, 9'h1FF, 3'b111, 3'b000);
    check(presentState == '0, "R1", presentState, 0);
  endtask

  task automatic t_capture();
    cycle(1'b0, 1'b1, 9'h0F3, 3'b101, 3'b110);
    cycle(1'b0, 1'b1, 9'h10C, 3'b011, 3'b001);
    cycle(1'b0, 1'b1, 9'h155, 3'b000, 3'b111);
    check(presentState == 9'h155, "R2", presentState, 9'h155);
  endtask

  task automatic t_shift_load();
    logic [4:0] a, b, c;
    logic [STATE_W-1:0] want;
    a = 5'b10110; b = 5'b01101; c = 5'b11010;
    for (int t = 0; t < 5; t++) cycle(1'b0, 1'b0, 9'h1FF, {c[t], b[t], a[t]}, 3'b111);
    for (int k = 0; k < L0; k++) want[O0+k] = a[4-k];
    for (int k = 0; k < L1; k++) want[O1+k] = b[4-k];
    want[O2] = c[4];
    check(presentState == want, "R7", presentState, want);
    check(presentState[O2] == c[4], "R9", presentState[O2], c[4]);
    check(pinOut[2] == c[4], "R9", pinOut[2], c[4]);
  endtask

  task automatic t_unload();
    logic [STATE_W-1:0] cap;
    cap = 9'b1_011_01101;
    cycle(1'b0, 1'b1, cap, 3'b000, 3'b010);
    testCtl = 1'b0; pinIn = '0; #1;
    check(pinOut == {cap[8], cap[7], cap[4]}, "R8", pinOut, {cap[8], cap[7], cap[4]});
    for (int j = 1; j <= 6; j++) begin
      logic [CHAINS-1:0] want;
      cycle(1'b0, 1'b0, 9'h000, 3'b000, 3'b000);
      want[0] = (j < L0) ? cap[O0+L0-1-j] : 1'b0;
      want[1] = (j < L1) ? cap[O1+L1-1-j] : 1'b0;
      want[2] = 1'b0;
      check(pinOut == want, "R8", pinOut, want);
    end
  endtask

  task automatic t_mixed();
    cycle(1'b0, 1'b0, 9'h0AA, 3'b111, 3'b001);
    cycle(1'b0, 1'b1, 9'h0AA, 3'b100, 3'b001);
    cycle(1'b0, 1'b0, 9'h133, 3'b010, 3'b110);
    cycle(1'b0, 1'b0, 9'h133, 3'b101, 3'b110);
    check(pinOut[2] == 1'b1, "R9", pinOut[2], 1);
    cycle(1'b1, 1'b1, 9'h1FF, 3'b111, 3'b111);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_capture();
    t_shift_load();
    t_unload();
    t_mixed();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule